// File: doc/BRIEF.md
# Preemptive Special Character Injector

This block sits between the transmit FIFO of an asynchronous serial transmitter and its holding and shift registers. Normal traffic moves from the FIFO into the serializer only while the transmitter is enabled and neither flow-control mechanism has paused it. A host can also push one special character ahead of everything still queued. It writes a command register that holds a send flag and a select field. The select field picks one of a small set of host-writable special-character registers.

A pending command first lets the character already in the holding register and the shift register finish. It then loads the chosen special character, even when in-band flow control, out-of-band flow control or the transmitter enable would block ordinary data. The block acknowledges the command by clearing the whole command register. After that, the queued FIFO data resumes under the usual gating. A select value with no matching special-character register cancels the command, sends nothing, and raises a one-cycle error pulse.

Top module: `spc_inject`

## Requirements
- R1: The command register is SEL_W+1 bits wide: bit SEL_W is the send flag and bits SEL_W-1:0 are the select. A host write made while no command is pending is stored, and `cmd_q` reads the stored value from the next cycle on.
- R2: In the clock edge that ends a cycle in which `ser_spc` is high, the whole command register clears, so `cmd_q` reads 0 in the following cycle.
- R3: A pending valid command loads its character only in a cycle where both `shreg_busy` and `hold_full` are low. That load is `ser_load`=1 and `ser_spc`=1, with `ser_data` equal to the selected special-character register.
- R4: While a command is pending, `fifo_pop` stays low, so queued FIFO data is loaded only after the special character.
- R5: A pending special character is loaded regardless of `ib_stop`.
- R6: A pending special character is loaded regardless of `oob_stop`.
- R7: A pending special character is loaded regardless of `tx_en` being low.
- R8: A select value of NUM_SPC or above (4 to 7 by default) never loads anything. The register clears at the edge after the command is stored, and `cmd_err` is high for exactly that one following cycle.
- R9: A command write made while the send flag is set is dropped: it changes neither `cmd_q` nor what is sent.
- R10: A FIFO load happens exactly when `fifo_valid` is high, `hold_full` is low, `tx_en` is high, `ib_stop` and `oob_stop` are low, and no command is pending. In that case `ser_load` and `fifo_pop` are 1, `ser_spc` is 0 and `ser_data` equals `fifo_data`.
- R11: `spc_we` writes `spc_wdata` into special-character register `spc_idx` when `spc_idx` is below NUM_SPC. A write to a higher index changes no register.
- R12: After reset, `cmd_q` is 0, `cmd_err` is 0 and every special-character register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | SEL_W+1 | Send flag (MSB) and select value |
| cmd_q | output | SEL_W+1 | Current command register contents |
| cmd_err | output | 1 | One-cycle pulse on a cancelled out-of-range command |
| spc_we | input | 1 | Special-character register write strobe |
| spc_idx | input | SEL_W | Special-character register index |
| spc_wdata | input | DATA_W | Special-character write data |
| shreg_busy | input | 1 | Shift register still transmitting |
| hold_full | input | 1 | Holding register occupied |
| ib_stop | input | 1 | In-band flow control has paused output |
| oob_stop | input | 1 | Out-of-band flow control holds off output |
| tx_en | input | 1 | Transmitter enable |
| fifo_valid | input | 1 | FIFO head holds a character |
| fifo_data | input | DATA_W | FIFO head character |
| fifo_pop | output | 1 | FIFO head consumed this cycle |
| ser_load | output | 1 | Character presented to the serializer this cycle |
| ser_data | output | DATA_W | Character to load |
| ser_spc | output | 1 | The load is a special character |

## Verification
The bench goes after four corner cases. The first is a command that arrives while the holding register is already empty but the shift register is still busy. A design that looks only at the holding register would cut into the character being sent. The second is a pending command when the FIFO is ready to be popped in the same cycle. A design that lets the FIFO win would put queued data ahead of the special character. The bench also applies each override (in-band stop, out-of-band stop, disabled transmitter) with a command pending. A design that gates the special path like ordinary data would stall there and never acknowledge. Finally, the bench writes commands while one is pending, issues out-of-range selects and writes out-of-range register indices. A wrong design would replace the pending select, send a stale register, or hold the error flag for more than one cycle.

// File: rtl/spc_inject_pkg.sv
package spc_inject_pkg;

   // Which source feeds the serializer in a cycle
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_FIFO = 2'd1,
      SRC_SPC  = 2'd2
   } load_src_e;

   // Transmitter status seen by the arbiter
   typedef struct packed {
      logic shreg_busy;
      logic hold_full;
      logic ib_stop;
      logic oob_stop;
      logic tx_en;
   } tx_stat_t;

endpackage

// File: rtl/spc_inject_file.sv
module spc_inject_file #(
   parameter int DATA_W  = 8,
   parameter int NUM_SPC = 4,
   parameter int SEL_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data
);

   localparam int FLAT_W = NUM_SPC * DATA_W;

   logic [FLAT_W-1:0] flat;

   generate
      if (NUM_SPC < 1 || NUM_SPC > (1 << SEL_W)) begin : g_bad_count
         $error("spc_inject_file: NUM_SPC must lie in 1..2**SEL_W");
      end
      for (genvar i = 0; i < NUM_SPC; i++) begin : g_ent
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (wr_idx == i[SEL_W-1:0])) begin
               q <= wr_data;
            end
         end
         assign flat[i*DATA_W +: DATA_W] = q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_SPC; i++) begin
         if (rd_sel == i[SEL_W-1:0]) begin
            rd_data = flat[i*DATA_W +: DATA_W];
         end
      end
   end

   logic [SEL_W:0] wr_idx_ext;
   assign wr_idx_ext = {1'b0, wr_idx};

   AST_FILE_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx_ext >= NUM_SPC[SEL_W:0])) |=> $stable(flat)); // R11

endmodule

// File: rtl/spc_inject_cmd.sv
module spc_inject_cmd #(
   parameter int SEL_W   = 3,
   parameter int NUM_SPC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W:0]   wr_data,
   input  logic             take,
   output logic [SEL_W:0]   cmd_q,
   output logic             pending,
   output logic [SEL_W-1:0] sel,
   output logic             bad,
   output logic             err_q
);

   localparam logic [SEL_W:0] SEL_LIM = NUM_SPC[SEL_W:0];

   assign pending = cmd_q[SEL_W];
   assign sel     = cmd_q[SEL_W-1:0];

   generate
      if (NUM_SPC == (1 << SEL_W)) begin : g_full_map
         // every select value names a register
         assign bad = 1'b0;
      end else begin : g_part_map
         assign bad = pending && ({1'b0, sel} >= SEL_LIM);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= bad;
         if (take || bad) begin
            cmd_q <= '0;
         end else if (wr_en && !pending) begin
            cmd_q <= wr_data;
         end
      end
   end

   AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && wr_en && !take && !bad) |=> $stable(cmd_q)); // R9

   AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> !err_q); // R8

   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (cmd_q[SEL_W] == 1'b0 || $past(wr_en))); // R8

endmodule

// File: rtl/spc_inject_arb.sv
module spc_inject_arb
   import spc_inject_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  tx_stat_t          stat,
   input  logic              pending,
   input  logic              bad,
   input  logic [DATA_W-1:0] spc_data,
   input  logic              fifo_valid,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              take,
   output logic              fifo_pop,
   output logic              ser_load,
   output logic [DATA_W-1:0] ser_data,
   output logic              ser_spc
);

   logic      line_idle;
   logic      fifo_open;
   logic      spc_go;
   logic      fifo_go;
   load_src_e src;

   // special path waits only for the serializer to drain
   assign line_idle = !stat.shreg_busy && !stat.hold_full;
   // ordinary path additionally respects gating
   assign fifo_open = !stat.hold_full && stat.tx_en && !stat.ib_stop && !stat.oob_stop;

   assign spc_go  = pending && !bad && line_idle;
   assign fifo_go = fifo_valid && fifo_open && !pending;

   always_comb begin
      if (spc_go)       src = SRC_SPC;
      else if (fifo_go) src = SRC_FIFO;
      else              src = SRC_NONE;
   end

   always_comb begin
      ser_load = 1'b0;
      ser_spc  = 1'b0;
      fifo_pop = 1'b0;
      ser_data = '0;
      case (src)
         SRC_SPC: begin
            ser_load = 1'b1;
            ser_spc  = 1'b1;
            ser_data = spc_data;
         end
         SRC_FIFO: begin
            ser_load = 1'b1;
            fifo_pop = 1'b1;
            ser_data = fifo_data;
         end
         default: ;
      endcase
   end

   assign take = spc_go;

endmodule

// File: rtl/spc_inject.sv
module spc_inject
   import spc_inject_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 3,
   parameter int NUM_SPC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [SEL_W:0]    cmd_wdata,
   output logic [SEL_W:0]    cmd_q,
   output logic              cmd_err,
   input  logic              spc_we,
   input  logic [SEL_W-1:0]  spc_idx,
   input  logic [DATA_W-1:0] spc_wdata,
   input  logic              shreg_busy,
   input  logic              hold_full,
   input  logic              ib_stop,
   input  logic              oob_stop,
   input  logic              tx_en,
   input  logic              fifo_valid,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              fifo_pop,
   output logic              ser_load,
   output logic [DATA_W-1:0] ser_data,
   output logic              ser_spc
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("spc_inject: DATA_W must be 5..9 bits");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("spc_inject: SEL_W must be at least 1");
      end
   endgenerate

   tx_stat_t          stat;
   logic              pending;
   logic              bad;
   logic              take;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] spc_data;

   assign stat = '{shreg_busy: shreg_busy, hold_full: hold_full,
                   ib_stop: ib_stop, oob_stop: oob_stop, tx_en: tx_en};

   spc_inject_cmd #(.SEL_W(SEL_W), .NUM_SPC(NUM_SPC)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmd_we),
      .wr_data (cmd_wdata),
      .take    (take),
      .cmd_q   (cmd_q),
      .pending (pending),
      .sel     (sel),
      .bad     (bad),
      .err_q   (cmd_err)
   );

   spc_inject_file #(.DATA_W(DATA_W), .NUM_SPC(NUM_SPC), .SEL_W(SEL_W)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (spc_we),
      .wr_idx  (spc_idx),
      .wr_data (spc_wdata),
      .rd_sel  (sel),
      .rd_data (spc_data)
   );

   spc_inject_arb #(.DATA_W(DATA_W)) u_arb (
      .stat       (stat),
      .pending    (pending),
      .bad        (bad),
      .spc_data   (spc_data),
      .fifo_valid (fifo_valid),
      .fifo_data  (fifo_data),
      .take       (take),
      .fifo_pop   (fifo_pop),
      .ser_load   (ser_load),
      .ser_data   (ser_data),
      .ser_spc    (ser_spc)
   );

   AST_SPC_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ser_spc |=> (cmd_q == '0)); // R2

   AST_SPC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      ser_spc |-> (!shreg_busy && !hold_full)); // R3

   AST_FIFO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (tx_en && !ib_stop && !oob_stop && !hold_full && fifo_valid)); // R10

   AST_NO_POP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q[SEL_W] |-> !fifo_pop); // R4

   AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(!ser_load || !ser_spc)); // R8

endmodule

// File: tb/spc_inject_test.sv
module spc_inject_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int SW  = 3;
   localparam int NSP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [SW:0]   cmd_wdata = '0;
   logic [SW:0]   cmd_q;
   logic          cmd_err;
   logic          spc_we = 1'b0;
   logic [SW-1:0] spc_idx = '0;
   logic [DW-1:0] spc_wdata = '0;
   logic          shreg_busy = 1'b0;
   logic          hold_full = 1'b0;
   logic          ib_stop = 1'b0;
   logic          oob_stop = 1'b0;
   logic          tx_en = 1'b0;
   logic          fifo_valid = 1'b0;
   logic [DW-1:0] fifo_data = '0;
   logic          fifo_pop;
   logic          ser_load;
   logic [DW-1:0] ser_data;
   logic          ser_spc;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model state
   logic [SW:0]   m_cmd = '0;
   logic          m_err = 1'b0;
   logic [DW-1:0] m_file [NSP];

   always #(CLK_PERIOD/2) clk = ~clk;

   spc_inject #(.DATA_W(DW), .SEL_W(SW), .NUM_SPC(NSP)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_q(cmd_q), .cmd_err(cmd_err), .spc_we(spc_we), .spc_idx(spc_idx),
      .spc_wdata(spc_wdata), .shreg_busy(shreg_busy), .hold_full(hold_full),
      .ib_stop(ib_stop), .oob_stop(oob_stop), .tx_en(tx_en),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .ser_load(ser_load), .ser_data(ser_data), .ser_spc(ser_spc)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit sel_bad(input logic [SW:0] c);
      return c[SW] && (int'(c[SW-1:0]) >= NSP);
   endfunction

   function automatic bit spc_ready(input logic [SW:0] c, input logic busy, input logic hold);
      return c[SW] && !sel_bad(c) && !busy && !hold;
   endfunction

   function automatic bit fifo_ready(input logic [SW:0] c);
      return fifo_valid && !hold_full && tx_en && !ib_stop && !oob_stop && !c[SW];
   endfunction

   // compare one cycle against the model, then advance the model across the edge
   task automatic step();
      bit            sgo;
      bit            fgo;
      bit            bd;
      logic [DW-1:0] ed;
      #1;
      bd  = sel_bad(m_cmd);
      sgo = spc_ready(m_cmd, shreg_busy, hold_full);
      fgo = fifo_ready(m_cmd);
      ed  = sgo ? m_file[m_cmd[SW-1:0]] : (fgo ? fifo_data : '0);
      chk(cmd_q == m_cmd, "R1 R2 R9 cmd_q", int'(cmd_q), int'(m_cmd));
      chk(cmd_err == m_err, "R8 cmd_err", int'(cmd_err), int'(m_err));
      chk(ser_spc == sgo, "R3 R5 R6 R7 ser_spc", int'(ser_spc), int'(sgo));
      chk(fifo_pop == fgo, "R4 R10 fifo_pop", int'(fifo_pop), int'(fgo));
      chk(ser_load == (sgo | fgo), "R3 R10 ser_load", int'(ser_load), int'(sgo | fgo));
      if (sgo || fgo)
         chk(ser_data == ed, "R3 R10 R11 ser_data", int'(ser_data), int'(ed));
      @(posedge clk);
      m_err = bd;
      if (sgo || bd) m_cmd = '0;
      else if (cmd_we && !m_cmd[SW]) m_cmd = cmd_wdata;
      if (spc_we && int'(spc_idx) < NSP) m_file[spc_idx] = spc_wdata;
      @(negedge clk);
   endtask

   task automatic wr_cmd(input logic [SW:0] v);
      cmd_we = 1'b1; cmd_wdata = v;
      step();
      cmd_we = 1'b0; cmd_wdata = '0;
   endtask

   task automatic wr_spc(input int idx, input logic [DW-1:0] v);
      spc_we = 1'b1; spc_idx = idx[SW-1:0]; spc_wdata = v;
      step();
      spc_we = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed_v;
      seed_v = $urandom(32'd24681);
      for (int i = 0; i < NSP; i++) m_file[i] = '0;

      repeat (3) @(negedge clk);
      #1;
      // R12: reset state
      chk(cmd_q == '0, "R12 cmd_q", int'(cmd_q), 0);
      chk(cmd_err == 1'b0, "R12 cmd_err", int'(cmd_err), 0);
      chk(ser_load == 1'b0, "R12 ser_load", int'(ser_load), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R12 special registers read zero: send select 1 on an idle line
      wr_cmd({1'b1, 3'd1});
      step();

      // R11: load the register file, out-of-range index ignored
      wr_spc(0, 8'hA0); wr_spc(1, 8'hA1); wr_spc(2, 8'hA2); wr_spc(3, 8'hA3);
      wr_spc(5, 8'h55);
      for (int i = 0; i < NSP; i++) begin
         wr_cmd({1'b1, i[SW-1:0]});
         step();
      end

      // R3 R4: serializer busy, FIFO ready; shift reg drains after holding reg
      tx_en = 1'b1; fifo_valid = 1'b1; fifo_data = 8'h31;
      shreg_busy = 1'b1; hold_full = 1'b1;
      wr_cmd({1'b1, 3'd2});
      step();
      hold_full = 1'b0;          // holding empty, shift still busy: nothing moves
      step(); step();
      shreg_busy = 1'b0;         // special goes first, FIFO next
      step(); step();

      // R9: write while pending is dropped
      shreg_busy = 1'b1;
      wr_cmd({1'b1, 3'd0});
      wr_cmd({1'b1, 3'd3});
      step();
      shreg_busy = 1'b0;
      step(); step();

      // R5 R6 R7: each override with FIFO gated off
      ib_stop = 1'b1;  wr_cmd({1'b1, 3'd1}); step(); step(); ib_stop = 1'b0;
      oob_stop = 1'b1; wr_cmd({1'b1, 3'd2}); step(); step(); oob_stop = 1'b0;
      tx_en = 1'b0;    wr_cmd({1'b1, 3'd3}); step(); step(); tx_en = 1'b1;

      // R8: out-of-range selects, including back-to-back
      wr_cmd({1'b1, 3'd6}); step(); step();
      wr_cmd({1'b1, 3'd4}); wr_cmd({1'b1, 3'd7}); step(); step();
      // R1: write with send clear is stored and stays
      wr_cmd({1'b0, 3'd5}); step();
      wr_cmd({1'b1, 3'd0}); step(); step();

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         shreg_busy = ($urandom_range(0, 3) == 0);
         hold_full  = ($urandom_range(0, 3) == 0);
         ib_stop    = ($urandom_range(0, 5) == 0);
         oob_stop   = ($urandom_range(0, 5) == 0);
         tx_en      = ($urandom_range(0, 7) != 0);
         fifo_valid = ($urandom_range(0, 2) != 0);
         fifo_data  = DW'($urandom);
         cmd_we     = ($urandom_range(0, 7) == 0);
         cmd_wdata  = {($urandom_range(0, 4) != 0), 3'($urandom)};
         spc_we     = ($urandom_range(0, 15) == 0);
         spc_idx    = 3'($urandom);
         spc_wdata  = DW'($urandom);
         step();
      end
      cmd_we = 1'b0; spc_we = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule